// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Preset

This block is a four-bit synchronous counter that can run in either direction. A parameter selects one of two counting ranges at build time: plain binary, which covers 0 to 15, or decimal decade, which covers 0 to 9. All state bits update together on the rising clock edge, so the count never passes through intermediate values. An active-low enable gates counting. A direction input chooses increment (low) or decrement (high). An active-low preset input copies a four-bit value into the count at once, without waiting for a clock edge.

Two outputs support building wider counters out of several stages. The limit flag is high for as long as the count sits at the end of its range in the current direction: the maximum when counting up, zero when counting down. The active-low ripple output pulses low during the low half of the clock, but only when the limit is present and counting is enabled. Its rising edge therefore lines up with the clock edge on which the stage wraps. A following stage can take this pulse as its enable when it shares the clock. It can instead take the pulse as its clock when the enable is shared, which is how the bench chains two decade stages into a 0 to 99 counter.

Top module: `rev_counter`

## Requirements
- R1: With `load_n` high, `rst` high at a rising clock edge sets `count` to 0.
- R2: With `en_n` high and `load_n` high, `count` holds its value across clock edges.
- R3: Binary mode, `dir` = 0, `en_n` = 0: each rising edge adds one, and 15 wraps to 0.
- R4: Binary mode, `dir` = 1, `en_n` = 0: each rising edge subtracts one, and 0 wraps to 15.
- R5: Decade mode, `en_n` = 0: counting up, 9 wraps to 0; counting down, 0 wraps to 9. Other valid values step by one.
- R6: Decade mode, from a preset value of 10 to 15: an up count goes to 0 and a down count goes to the value minus one. `at_limit` is never high for these values.
- R7: `load_n` low sets `count` to `load_val` immediately, at either clock level. While it stays low, it overrides counting and `rst`.
- R8: `at_limit` is high exactly when `dir` = 0 and the count equals the top value (15 binary, 9 decade), or when `dir` = 1 and the count is 0. It does not depend on `en_n`.
- R9: `ripple_n` is low only while the clock is low, `at_limit` is high and `en_n` is low. It is high during the whole high half of the clock.
- R10: Two decade stages chain into a two-digit counter: the units `ripple_n` drives the tens clock, and both stages share enable and direction. The pair counts through 0 to 99 upward and back downward with the tens digit changing exactly when the units digit wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear |
| en_n | input | 1 | Active-low count enable |
| dir | input | 1 | Direction: 0 up, 1 down |
| load_n | input | 1 | Asynchronous active-low preset |
| load_val | input | 4 | Preset value |
| count | output | 4 | Current count |
| at_limit | output | 1 | End-of-range flag for the current direction |
| ripple_n | output | 1 | Active-low cascade pulse during clock low half |

## Verification
The step and hold properties assume that any preset pulse between two edges is visible to the checker. The checker therefore records each falling edge of `load_n` and excuses the following edge from the counting rules. The reset property assumes `rst` is never raised in the same cycle that a preset begins. The stimulus changes enable, direction and preset only during the high half of the clock, when `ripple_n` is forced high. This keeps the chained tens stage from seeing a spurious clock edge. The ripple check samples the clock only at its falling edge, where its level is unambiguous.

// File: rtl/rev_counter_pkg.sv
package rev_counter_pkg;

    localparam int CNT_W   = 4;
    localparam int DEC_TOP = 9;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        MODE_BINARY = 1'b0,
        MODE_DECADE = 1'b1
    } cnt_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    typedef struct packed {
        logic at_top;
        logic at_floor;
        logic term;
    } term_t;

    function automatic cnt_t top_value(cnt_mode_e m);
        return (m == MODE_DECADE) ? cnt_t'(DEC_TOP) : {CNT_W{1'b1}};
    endfunction

endpackage

// File: rtl/rcnt_step.sv
module rcnt_step
    import rev_counter_pkg::*;
#(
    parameter cnt_mode_e MODE = MODE_DECADE
) (
    input  cnt_t cur,
    input  logic dir,
    output cnt_t nxt
);
    localparam cnt_t TOP = top_value(MODE);

    generate
        if (MODE == MODE_DECADE) begin : g_decade
            always_comb begin
                if (cnt_dir_e'(dir) == DIR_DOWN) begin
                    nxt = (cur == '0) ? TOP : cur - cnt_t'(1);
                end else begin
                    // values at or beyond the top fold back to zero
                    nxt = (cur >= TOP) ? '0 : cur + cnt_t'(1);
                end
            end
        end else begin : g_binary
            always_comb begin
                if (cnt_dir_e'(dir) == DIR_DOWN) nxt = cur - cnt_t'(1);
                else                             nxt = cur + cnt_t'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/rcnt_term.sv
module rcnt_term
    import rev_counter_pkg::*;
#(
    parameter cnt_mode_e MODE = MODE_DECADE
) (
    input  logic  clk,
    input  cnt_t  cur,
    input  logic  dir,
    input  logic  en_n,
    output term_t flags,
    output logic  ripple_n
);
    localparam cnt_t TOP = top_value(MODE);

    always_comb begin
        flags.at_top   = (cur == TOP);
        flags.at_floor = (cur == '0);
        flags.term     = (cnt_dir_e'(dir) == DIR_DOWN) ? flags.at_floor : flags.at_top;
    end

    // low only in the low clock half, so the rising edge aligns with the wrap
    assign ripple_n = ~(flags.term & ~en_n & ~clk);
endmodule

// File: rtl/rcnt_state.sv
module rcnt_state
    import rev_counter_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    input  logic load_n,
    input  cnt_t load_val,
    input  cnt_t nxt,
    output cnt_t q
);
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n)    q <= load_val;
        else if (rst)   q <= '0;
        else if (!en_n) q <= nxt;
    end
endmodule

// File: rtl/rev_counter.sv
module rev_counter
    import rev_counter_pkg::*;
#(
    parameter cnt_mode_e MODE = MODE_DECADE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_n,
    input  logic             dir,
    input  logic             load_n,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             at_limit,
    output logic             ripple_n
);
    cnt_t  cur_q;
    cnt_t  nxt_c;
    term_t flags;

    rcnt_step #(.MODE(MODE)) u_step (
        .cur (cur_q),
        .dir (dir),
        .nxt (nxt_c)
    );

    rcnt_state u_state (
        .clk      (clk),
        .rst      (rst),
        .en_n     (en_n),
        .load_n   (load_n),
        .load_val (load_val),
        .nxt      (nxt_c),
        .q        (cur_q)
    );

    rcnt_term #(.MODE(MODE)) u_term (
        .clk      (clk),
        .cur      (cur_q),
        .dir      (dir),
        .en_n     (en_n),
        .flags    (flags),
        .ripple_n (ripple_n)
    );

    assign count    = cur_q;
    assign at_limit = flags.term;
endmodule

// File: rtl/rev_counter_chk.sv
module rev_counter_chk
    import rev_counter_pkg::*;
#(
    parameter cnt_mode_e MODE = MODE_DECADE
) (
    input logic             clk,
    input logic             rst,
    input logic             en_n,
    input logic             dir,
    input logic             load_n,
    input logic [CNT_W-1:0] count,
    input logic             at_limit,
    input logic             ripple_n
);
    localparam cnt_t TOP = top_value(MODE);

    // flips on every preset; a change excuses the next edge from step rules
    logic ld_tog = 1'b0;
    always @(negedge load_n) ld_tog <= ~ld_tog;

    a_r1_sync_clear: assert property (@(posedge clk) disable iff (!load_n)
        (rst && load_n) |=> (!$stable(ld_tog) || count == '0));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (en_n && load_n) |=> (!$stable(ld_tog) || $stable(count)));

    a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
        (!en_n && load_n && !dir && count < TOP)
        |=> (!$stable(ld_tog) || count == $past(count) + cnt_t'(1)));

    a_r5_up_wrap: assert property (@(posedge clk) disable iff (rst)
        (!en_n && load_n && !dir && count >= TOP)
        |=> (!$stable(ld_tog) || count == '0));

    a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
        (!en_n && load_n && dir && count != '0)
        |=> (!$stable(ld_tog) || count == $past(count) - cnt_t'(1)));

    a_r6_no_flag_invalid: assert property (@(posedge clk) disable iff (rst)
        (count > TOP) |-> !at_limit);

    a_r8_flag_at_end: assert property (@(posedge clk) disable iff (rst)
        at_limit |-> (count == '0 || count == TOP));

    a_r9_idle_high: assert property (@(negedge clk) disable iff (rst)
        clk |-> ripple_n);
endmodule

bind rev_counter rev_counter_chk #(.MODE(MODE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en_n     (en_n),
    .dir      (dir),
    .load_n   (load_n),
    .count    (count),
    .at_limit (at_limit),
    .ripple_n (ripple_n)
);

// File: tb/sim_rev_counter.sv
`timescale 1ns/1ps
module sim_rev_counter;
    import rev_counter_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic       b_en_n, b_dir, b_ld_n;
    logic [3:0] b_din, b_q;
    logic       b_mm, b_rco;
    logic       d_en_n, d_dir, d_ld_n;
    logic [3:0] d_din, d_din_hi, u_q, t_q;
    logic       u_mm, u_rco, t_mm, t_rco;

    int errs = 0;
    int checks = 0;
    int m_b, m_u, m_t;
    bit done = 1'b0;

    rev_counter #(.MODE(MODE_BINARY)) u0 (
        .clk(clk), .rst(rst), .en_n(b_en_n), .dir(b_dir), .load_n(b_ld_n),
        .load_val(b_din), .count(b_q), .at_limit(b_mm), .ripple_n(b_rco));

    rev_counter #(.MODE(MODE_DECADE)) u_units (
        .clk(clk), .rst(rst), .en_n(d_en_n), .dir(d_dir), .load_n(d_ld_n),
        .load_val(d_din), .count(u_q), .at_limit(u_mm), .ripple_n(u_rco));

    // tens stage clocked by the units ripple pulse, enable shared (R10)
    rev_counter #(.MODE(MODE_DECADE)) u_tens (
        .clk(u_rco), .rst(1'b0), .en_n(d_en_n), .dir(d_dir), .load_n(d_ld_n),
        .load_val(d_din_hi), .count(t_q), .at_limit(t_mm), .ripple_n(t_rco));

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit tc_f(int v, logic d, int top);
        return d ? (v == 0) : (v == top);
    endfunction

    function automatic int dec_f(int v, logic d);
        if (d) return (v == 0) ? 9 : v - 1;
        return (v >= 9) ? 0 : v + 1;
    endfunction

    // inputs are set in the clock high half before calling
    task automatic tick(string req);
        bit carry;
        @(negedge clk); #1;
        chk(req, "bin count", b_q, m_b);
        chk("R8", "bin flag", b_mm, tc_f(m_b, b_dir, 15));
        chk("R9", "bin ripple low half", b_rco, !(tc_f(m_b, b_dir, 15) && !b_en_n));
        chk(req, "units count", u_q, m_u);
        chk("R8", "units flag", u_mm, tc_f(m_u, d_dir, 9));
        chk("R9", "units ripple low half", u_rco, !(tc_f(m_u, d_dir, 9) && !d_en_n));
        chk("R10", "tens count", t_q, m_t);
        @(posedge clk);
        if (!b_ld_n)     m_b = b_din;
        else if (rst)    m_b = 0;
        else if (!b_en_n) m_b = b_dir ? (m_b + 15) % 16 : (m_b + 1) % 16;
        carry = d_ld_n && !d_en_n && tc_f(m_u, d_dir, 9);
        if (!d_ld_n) begin
            m_u = d_din;
            m_t = d_din_hi;
        end else begin
            if (rst)          m_u = 0;
            else if (!d_en_n) m_u = dec_f(m_u, d_dir);
            if (carry)        m_t = dec_f(m_t, d_dir);
        end
        #2;
        chk("R9", "bin ripple high half", b_rco, 1);
        chk("R9", "units ripple high half", u_rco, 1);
    endtask

    initial begin
        rst = 1'b1;
        b_en_n = 1'b1; b_dir = 1'b0; b_ld_n = 1'b1; b_din = 4'd7;
        d_en_n = 1'b1; d_dir = 1'b0; d_ld_n = 1'b1; d_din = 4'd3; d_din_hi = 4'd0;
        #1;
        b_ld_n = 1'b0; d_ld_n = 1'b0;
        m_b = 7; m_u = 3; m_t = 0;
        @(posedge clk); #2;
        b_ld_n = 1'b1; d_ld_n = 1'b1;

        tick("R1");                         // preset value visible, clear at edge
        rst = 1'b0;
        tick("R1");
        repeat (3) tick("R2");

        b_en_n = 1'b0; b_dir = 1'b0;
        repeat (18) tick("R3");
        b_dir = 1'b1;
        repeat (18) tick("R4");
        b_en_n = 1'b1;

        d_en_n = 1'b0; d_dir = 1'b0;
        repeat (120) tick("R5 R10");
        d_dir = 1'b1;
        repeat (125) tick("R5 R10");
        d_en_n = 1'b1;
        repeat (3) tick("R2");

        // preset in the high half of the clock while counting
        b_en_n = 1'b0; b_dir = 1'b0;
        b_ld_n = 1'b0; b_din = 4'd12;
        #1; chk("R7", "async preset", b_q, 12);
        m_b = 12;
        tick("R7");
        b_ld_n = 1'b1;
        tick("R7");

        // preset wins over clear
        rst = 1'b1; b_ld_n = 1'b0; b_din = 4'd5;
        #1; m_b = 5;
        tick("R7");
        tick("R7");
        rst = 1'b0; b_ld_n = 1'b1;
        tick("R3");

        // out-of-range decade preset, counting up
        d_en_n = 1'b1; d_dir = 1'b0;
        d_ld_n = 1'b0; d_din = 4'd13; d_din_hi = 4'd2;
        #1; chk("R6", "decade preset 13", u_q, 13);
        m_u = 13; m_t = 2;
        tick("R6");
        d_ld_n = 1'b1; d_en_n = 1'b0;
        repeat (3) tick("R6");

        // out-of-range decade preset, counting down
        d_en_n = 1'b1; d_dir = 1'b1;
        d_ld_n = 1'b0; d_din = 4'd15; d_din_hi = 4'd4;
        #1; m_u = 15; m_t = 4;
        tick("R6");
        d_ld_n = 1'b1; d_en_n = 1'b0;
        repeat (8) tick("R6");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++; errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule